// File: doc/BRIEF.md
# Bank-Conflict Serializer with Read Broadcast

This block sits in front of a multi-bank scratchpad and turns one vector memory request into a series of conflict-free issue cycles. Each of the L lanes brings a bank index, an in-bank offset and an enable bit. A single store flag applies to all lanes. In every clock cycle the block picks the lanes that can share the banks without collision and reports them on a served mask. Lanes that still collide are held and issued in the cycles that follow.

Priority is fixed by lane number, and lane 0 ranks highest. A lane collides when an enabled lane of higher rank targets the same bank. For reads there is one exemption. The first pending lane sets a broadcast word (bank and offset), and every pending lane that reads exactly that word is served in the same cycle. A request with no collision is fully issued in the cycle it arrives, and `ready` stays high, so conflict-free requests can follow each other with no gap. A request with a collision makes the block busy. While busy, the block ignores its inputs and drives the captured bank indexes and offsets until the last lanes are issued.

Top module: `bank_serializer`

## Requirements
- R1: After reset, `ready` is 1. With `req_mask` all zero, `served_mask` is 0 and `last` is 0.
- R2: Lane 0 has the highest priority. Among pending lanes that share a bank and are not in the broadcast, only the lowest-numbered one is served in a given cycle.
- R3: When no two enabled lanes share a bank, every enabled lane is served in the arrival cycle, `last` is 1 and `ready` stays 1 in the next cycle.
- R4: On a read (`req_store`=0), every pending lane whose bank and offset both equal those of the lowest-numbered pending lane is served in the same cycle as that lane. On a store, no broadcast takes place.
- R5: If some bank is targeted by n enabled lanes that are not merged by broadcast, the request takes n cycles, and `ready` is 0 during the last n-1 of them.
- R6: While `ready` is 0, changes on `req_mask`, `req_store`, `req_bank` and `req_offs` have no effect. `iss_bank` and `iss_offs` hold the values captured in the arrival cycle.
- R7: In the arrival cycle, `last` is 1 exactly when the mask is non-zero and nothing is left pending. In a busy cycle, `last` is 1 exactly when that cycle serves all remaining lanes.
- R8: Each enabled lane is served in exactly one cycle, and the OR of the served masks over one request equals the request mask.
- R9: Disabled lanes are never served and never block an enabled lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_mask | input | LANES | Lane enables of the arriving request; a non-zero value in Ready starts a request |
| req_store | input | 1 | 1 for a store (no broadcast), 0 for a read |
| req_bank | input | LANES*BANK_W | Bank index per lane, lane i at bits [i*BANK_W +: BANK_W] |
| req_offs | input | LANES*OFFS_W | In-bank offset per lane, lane i at bits [i*OFFS_W +: OFFS_W] |
| ready | output | 1 | 1 when a new request is accepted this cycle |
| served_mask | output | LANES | Lanes issued this cycle |
| last | output | 1 | This cycle completes the request |
| iss_bank | output | LANES*BANK_W | Bank indexes of the request being issued (input in Ready, captured copy when busy) |
| iss_offs | output | LANES*OFFS_W | Offsets of the request being issued (input in Ready, captured copy when busy) |

## Verification
The assertions check these rules on every cycle:
- Served lanes are always a subset of the pending lanes.
- Every cycle with pending work serves at least one lane.
- No lane is served in two consecutive busy cycles.
- A store never issues two lanes to one bank.
- A leftover conflict always leads to a busy cycle, and a cleared one leads back to Ready.
- The issued datapath is stable while busy.

Other behaviour can only be shown by the bench's scenarios, which compare each cycle's served set with an independent model:
- the exact lane order under priority;
- which lanes the broadcast merges;
- the cycle count of an n-way conflict;
- the OR of all served masks equalling the request mask;
- inputs being ignored during the busy phase.

// File: rtl/bs_pkg.sv
`timescale 1ns/1ps
package bs_pkg;
  typedef enum logic {
    ST_READY = 1'b0,
    ST_BUSY  = 1'b1
  } bs_state_e;
endpackage

// File: rtl/bs_conflict_unit.sv
`timescale 1ns/1ps
module bs_conflict_unit #(
  parameter int LANES  = 8,
  parameter int BANK_W = 3,
  parameter int OFFS_W = 4
) (
  input  logic [LANES-1:0]             pending,
  input  logic                         is_store,
  input  logic [LANES-1:0][BANK_W-1:0] bank,
  input  logic [LANES-1:0][OFFS_W-1:0] offs,
  output logic [LANES-1:0]             served,
  output logic [LANES-1:0]             still,
  output logic                         conflict
);
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  // Lane j collides when any pending lane of lower number hits its bank.
  function automatic logic [LANES-1:0] collide_mask(
    input logic [LANES-1:0]             p,
    input logic [LANES-1:0][BANK_W-1:0] b
  );
    logic [LANES-1:0] c;
    c = '0;
    for (int j = 1; j < LANES; j++)
      for (int i = 0; i < j; i++)
        if (p[i] && (b[i] == b[j])) c[j] = 1'b1;
    return c;
  endfunction

  // Index of the highest-priority pending lane (0 when none).
  function automatic logic [IDX_W-1:0] lead_lane(input logic [LANES-1:0] p);
    logic [IDX_W-1:0] k;
    k = '0;
    for (int i = LANES-1; i >= 0; i--)
      if (p[i]) k = IDX_W'(i);
    return k;
  endfunction

  function automatic logic [LANES-1:0] bcast_mask(
    input logic [LANES-1:0]             p,
    input logic                         st,
    input logic [LANES-1:0][BANK_W-1:0] b,
    input logic [LANES-1:0][OFFS_W-1:0] o
  );
    logic [LANES-1:0] m;
    logic [IDX_W-1:0] k;
    k = lead_lane(p);
    for (int i = 0; i < LANES; i++)
      m[i] = !st && (b[i] == b[k]) && (o[i] == o[k]);
    return m;
  endfunction

  logic [LANES-1:0] cf_mask;
  logic [LANES-1:0] bc_mask;

  assign cf_mask  = collide_mask(pending, bank);
  assign bc_mask  = bcast_mask(pending, is_store, bank, offs);
  assign served   = pending & (bc_mask | ~cf_mask);
  assign still    = pending & ~served;
  assign conflict = |still;
endmodule

// File: rtl/bs_issue_ctrl.sv
`timescale 1ns/1ps
module bs_issue_ctrl
  import bs_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int BANK_W = 3,
  parameter int OFFS_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANES-1:0]             in_mask,
  input  logic                         in_store,
  input  logic [LANES-1:0][BANK_W-1:0] in_bank,
  input  logic [LANES-1:0][OFFS_W-1:0] in_offs,
  input  logic [LANES-1:0]             still,
  input  logic                         conflict,
  output logic [LANES-1:0]             pending,
  output logic                         cur_store,
  output logic [LANES-1:0][BANK_W-1:0] cur_bank,
  output logic [LANES-1:0][OFFS_W-1:0] cur_offs,
  output logic                         ready,
  output logic                         last
);
  bs_state_e                    state_q, state_d;
  logic [LANES-1:0]             still_q;
  logic                         store_q;
  logic [LANES-1:0][BANK_W-1:0] bank_q;
  logic [LANES-1:0][OFFS_W-1:0] offs_q;
  logic                         capture_en;

  assign ready      = (state_q == ST_READY);
  assign capture_en = ready;

  always_comb begin
    if (ready) begin
      pending   = in_mask;
      cur_store = in_store;
      cur_bank  = in_bank;
      cur_offs  = in_offs;
      last      = !conflict && (in_mask != '0);
    end else begin
      pending   = still_q;
      cur_store = store_q;
      cur_bank  = bank_q;
      cur_offs  = offs_q;
      last      = !conflict;
    end
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_READY: if (conflict)  state_d = ST_BUSY;
      ST_BUSY:  if (!conflict) state_d = ST_READY;
      default:  state_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_READY;
      still_q <= '0;
    end else begin
      state_q <= state_d;
      still_q <= still;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= 1'b0;
      bank_q  <= '0;
      offs_q  <= '0;
    end else if (capture_en) begin
      store_q <= in_store;
      bank_q  <= in_bank;
      offs_q  <= in_offs;
    end
  end
endmodule

// File: rtl/bank_serializer.sv
`timescale 1ns/1ps
module bank_serializer #(
  parameter int LANES  = 8,
  parameter int BANK_W = 3,
  parameter int OFFS_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES-1:0]         req_mask,
  input  logic                     req_store,
  input  logic [LANES*BANK_W-1:0]  req_bank,
  input  logic [LANES*OFFS_W-1:0]  req_offs,
  output logic                     ready,
  output logic [LANES-1:0]         served_mask,
  output logic                     last,
  output logic [LANES*BANK_W-1:0]  iss_bank,
  output logic [LANES*OFFS_W-1:0]  iss_offs
);
  logic [LANES-1:0][BANK_W-1:0] in_bank_v, cur_bank;
  logic [LANES-1:0][OFFS_W-1:0] in_offs_v, cur_offs;
  logic [LANES-1:0]             pending, still;
  logic                         conflict, cur_store;

  assign in_bank_v = req_bank;
  assign in_offs_v = req_offs;

  bs_issue_ctrl #(.LANES(LANES), .BANK_W(BANK_W), .OFFS_W(OFFS_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_mask   (req_mask),
    .in_store  (req_store),
    .in_bank   (in_bank_v),
    .in_offs   (in_offs_v),
    .still     (still),
    .conflict  (conflict),
    .pending   (pending),
    .cur_store (cur_store),
    .cur_bank  (cur_bank),
    .cur_offs  (cur_offs),
    .ready     (ready),
    .last      (last)
  );

  bs_conflict_unit #(.LANES(LANES), .BANK_W(BANK_W), .OFFS_W(OFFS_W)) u_cfl (
    .pending  (pending),
    .is_store (cur_store),
    .bank     (cur_bank),
    .offs     (cur_offs),
    .served   (served_mask),
    .still    (still),
    .conflict (conflict)
  );

  assign iss_bank = cur_bank;
  assign iss_offs = cur_offs;
endmodule

// File: rtl/bs_checker.sv
`timescale 1ns/1ps
module bs_checker #(
  parameter int LANES  = 8,
  parameter int BANK_W = 3,
  parameter int OFFS_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ready,
  input logic [LANES-1:0]        served_mask,
  input logic [LANES-1:0]        pending,
  input logic                    conflict,
  input logic                    cur_store,
  input logic [LANES*BANK_W-1:0] iss_bank,
  input logic [LANES*OFFS_W-1:0] iss_offs
);
  function automatic logic shared_bank(
    input logic [LANES-1:0]        m,
    input logic [LANES*BANK_W-1:0] b
  );
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < LANES; i++)
      for (int j = i + 1; j < LANES; j++)
        if (m[i] && m[j] && (b[i*BANK_W +: BANK_W] == b[j*BANK_W +: BANK_W]))
          hit = 1'b1;
    return hit;
  endfunction

  assert_served_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (served_mask & ~pending) == '0);

  assert_progress_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending != '0) |-> (served_mask != '0));

  assert_served_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> ((served_mask & $past(served_mask)) == '0));

  assert_store_one_per_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_store |-> !shared_bank(served_mask, iss_bank));

  assert_conflict_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> !ready);

  assert_clear_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !conflict |=> ready);

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> ($stable(iss_bank) && $stable(iss_offs)));
endmodule

bind bank_serializer bs_checker #(.LANES(LANES), .BANK_W(BANK_W), .OFFS_W(OFFS_W)) u_bs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ready       (ready),
  .served_mask (served_mask),
  .pending     (pending),
  .conflict    (conflict),
  .cur_store   (cur_store),
  .iss_bank    (iss_bank),
  .iss_offs    (iss_offs)
);

// File: tb/bank_serializer_tb_top.sv
`timescale 1ns/1ps
module bank_serializer_tb_top;
  localparam int L  = 8;
  localparam int BW = 3;
  localparam int OW = 4;
  localparam int NV = 8;

  typedef struct packed {
    logic [7:0]  mask;
    logic        st;
    logic [31:0] bnib;  // lane i bank in nibble i (low 3 bits)
    logic [31:0] onib;  // lane i offset in nibble i
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{8'hFF, 1'b0, 32'h76543210, 32'h00000000},
    '{8'hFF, 1'b0, 32'h33333333, 32'h55555555},
    '{8'hFF, 1'b1, 32'h33333333, 32'h55555555},
    '{8'h0F, 1'b0, 32'h00002222, 32'h00003210},
    '{8'h05, 1'b0, 32'h00001111, 32'h00003210},
    '{8'hFF, 1'b0, 32'h11110000, 32'h00003300},
    '{8'h00, 1'b0, 32'h76543210, 32'h00000000},
    '{8'h81, 1'b1, 32'h40000004, 32'h10000002}
  };
  string vtag [NV] = '{"R3", "R4", "R5", "R2", "R9", "R7", "R1", "R6"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [L-1:0]    req_mask = '0;
  logic            req_store = 1'b0;
  logic [L*BW-1:0] req_bank = '0;
  logic [L*OW-1:0] req_offs = '0;
  logic            ready, last;
  logic [L-1:0]    served_mask;
  logic [L*BW-1:0] iss_bank;
  logic [L*OW-1:0] iss_offs;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  bank_serializer #(.LANES(L), .BANK_W(BW), .OFFS_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_mask(req_mask), .req_store(req_store),
    .req_bank(req_bank), .req_offs(req_offs), .ready(ready),
    .served_mask(served_mask), .last(last), .iss_bank(iss_bank), .iss_offs(iss_offs)
  );

  function automatic logic [L*BW-1:0] nib2bank(input logic [31:0] n);
    logic [L*BW-1:0] r;
    for (int i = 0; i < L; i++) r[i*BW +: BW] = n[i*4 +: BW];
    return r;
  endfunction

  // Reference: walk lanes in order, remember banks already claimed.
  function automatic logic [L-1:0] ref_serve(input logic [L-1:0] rem, input logic st,
                                             input logic [31:0] bn, input logic [31:0] on);
    logic [L-1:0] srv;
    logic [7:0]   taken;
    logic [3:0]   lb, lo;
    bit           have_lead;
    srv = '0; taken = '0; have_lead = 0; lb = '0; lo = '0;
    for (int i = 0; i < L; i++) begin
      if (rem[i]) begin
        if (!have_lead) begin
          have_lead = 1; lb = {1'b0, bn[i*4 +: 3]}; lo = on[i*4 +: 4]; srv[i] = 1'b1;
        end else if (!st && ({1'b0, bn[i*4 +: 3]} == lb) && (on[i*4 +: 4] == lo)) begin
          srv[i] = 1'b1;
        end else if (!taken[bn[i*4 +: 3]]) begin
          srv[i] = 1'b1;
        end
        taken[bn[i*4 +: 3]] = 1'b1;
      end
    end
    return srv;
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(input int k);
    logic [L-1:0]    rem, exp, acc;
    logic [L*BW-1:0] cap_b;
    logic [L*OW-1:0] cap_o;
    int cyc, busy_obs;
    vec_t v;
    v = VT[k];
    rem = v.mask; acc = '0; cyc = 0; busy_obs = 0;
    @(negedge clk);
    req_mask = v.mask; req_store = v.st;
    req_bank = nib2bank(v.bnib); req_offs = v.onib;
    cap_b = req_bank; cap_o = req_offs;
    forever begin
      exp = ref_serve(rem, v.st, v.bnib, v.onib);
      if (cyc > 0) begin
        req_mask = ~v.mask; req_store = ~v.st; req_bank = ~cap_b; req_offs = ~cap_o;
      end
      #1;
      check(vtag[k], "served", 64'(served_mask), 64'(exp));
      check(vtag[k], "ready", 64'(ready), 64'(cyc == 0));
      check(vtag[k], "last", 64'(last), 64'(((rem & ~exp) == '0) && (rem != '0)));
      if (cyc > 0) begin
        check("R6", "held bank", 64'(iss_bank), 64'(cap_b));
        check("R6", "held offs", 64'(iss_offs), 64'(cap_o));
      end
      if (!ready) busy_obs++;
      acc |= served_mask;
      rem &= ~exp;
      cyc++;
      if (rem == '0) break;
      @(negedge clk);
    end
    check("R8", "union of served", 64'(acc), 64'(v.mask));
    check("R5", "busy cycles", 64'(busy_obs), 64'(cyc - 1));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1", "ready in reset", 64'(ready), 64'd1);
    check("R1", "served in reset", 64'(served_mask), 64'd0);
    check("R1", "last in reset", 64'(last), 64'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) run_vec(k);

    // R5: eight stores on one bank take eight cycles
    @(negedge clk);
    req_mask = 8'hFF; req_store = 1'b1; req_bank = nib2bank(32'h22222222); req_offs = '0;
    begin
      int cycles = 1;
      @(negedge clk);
      while (!ready && cycles < 20) begin cycles++; @(negedge clk); end
      check("R5", "8-way cycle count", 64'(cycles), 64'd8);
    end

    // R1: reset in the middle of a busy phase returns to ready
    req_mask = 8'h03; req_store = 1'b1; req_bank = '0; req_offs = '0;
    @(negedge clk);
    #1;
    check("R1", "busy before reset", 64'(ready), 64'd0);
    rst_n = 1'b0;
    req_mask = '0;
    #1;
    check("R1", "ready after reset", 64'(ready), 64'd1);
    check("R1", "idle served after reset", 64'(served_mask), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: two conflict-free requests back to back
    req_mask = 8'h0F; req_store = 1'b0; req_bank = nib2bank(32'h00003210); req_offs = '0;
    #1;
    check("R3", "first served", 64'(served_mask), 64'h0F);
    @(negedge clk);
    req_mask = 8'hF0; req_bank = nib2bank(32'h76540000);
    #1;
    check("R3", "second ready", 64'(ready), 64'd1);
    check("R3", "second served", 64'(served_mask), 64'hF0);
    check("R3", "second last", 64'(last), 64'd1);
    @(negedge clk);
    req_mask = '0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule